// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block is the device-side front end of a byte-wide asynchronous parallel flash bus, modelled inside a system-clock domain. The three active-low strobes (chip enable, output enable, write enable) are brought into the clock domain through two-flop synchronizers. The synchronized strobes are decoded into one of four bus modes: standby, read, write or output-disable. The block latches address and data on the correct strobe edges and hands each completed write to a command interpreter.

A write may be timed by either strobe. The address is captured when the later of chip enable and write enable goes low. The data byte is captured when the earlier of the two returns high. On reads the block drives one of three sources onto the data bus: array data, a status byte assembled from four command-logic flags, or an identification/protection readback. The identification/protection readback is selected by a separate high-voltage-detect input on address bit 9.

Completed writes leave through a valid/ready stream. `cmd_valid` rises one cycle after the write ends and stays high, with `cmd_addr` and `cmd_data` stable, until a cycle with `cmd_ready` high. The flash bus cannot be stalled. A write that completes while an earlier one is still unaccepted therefore replaces it. With `cmd_ready` held high, each write gives a single-cycle pulse.

Top module: `pflash_front`

## Requirements
- R1: Mode decode from synchronized strobes, shown on `bus_mode`: chip enable high gives standby (0) whatever the other strobes are. Chip enable low, output enable low, write enable high gives read (1). Chip enable low, output enable high, write enable low gives write (2). Every other combination gives output-disable (3). Each strobe change is reflected within 3 clock cycles.
- R2: `dq_oe` is high only in read mode; it is low in standby, write and output-disable.
- R3: In a write timed by write enable (chip enable already low), the address present when write enable falls is captured, and the data present when write enable rises is captured. Later address or data changes do not alter the captured values.
- R4: In a write timed by chip enable (write enable already low), address and data are captured on the falling and rising edges of chip enable respectively.
- R5: Each completed write raises `cmd_valid` with the captured address and data. These are held stable until `cmd_ready` is high, and exactly one handshake occurs per accepted write. A write completing while one is pending replaces it.
- R6: With `a9_hv` high and address bits {A6,A1,A0} = 000, a read returns 20h.
- R7: With `a9_hv` high and {A6,A1,A0} = 001, a read returns E3h.
- R8: With `a9_hv` high and {A6,A1,A0} = 010, a read returns 01h if `blk_prot[addr[18:16]]` is set, else 00h.
- R9: With `a9_hv` high and any other {A6,A1,A0} pattern, a read returns 00h.
- R10: With `a9_hv` low, a read returns `arr_rdata` when `stat_sel` is low. When `stat_sel` is high, it returns a status byte: poll on bit 7, toggle on bit 6, error on bit 5, erase timer on bit 3, all other bits 0.
- R11: Reset clears the captured address and data, deasserts `cmd_valid` and leaves `dq_oe` low with `bus_mode` at standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable strobe, active low, asynchronous |
| we_n | input | 1 | Write enable strobe, active low, asynchronous |
| addr_in | input | 19 | Bus address |
| dq_in | input | 8 | Data bus as seen from the pins |
| a9_hv | input | 1 | High-voltage detected on address bit 9 |
| arr_rdata | input | 8 | Array data for the current address |
| stat_sel | input | 1 | Command logic selects status byte for normal reads |
| st_poll | input | 1 | Data polling flag |
| st_toggle | input | 1 | Toggle flag |
| st_error | input | 1 | Error flag |
| st_etimer | input | 1 | Erase timer flag |
| blk_prot | input | 8 | Per-block protection flags |
| dq_out | output | 8 | Read data to drive on the bus |
| dq_oe | output | 1 | Bus driver enable |
| bus_mode | output | 2 | Decoded bus mode |
| cmd_valid | output | 1 | Captured write available |
| cmd_ready | input | 1 | Command interpreter accepts the write |
| cmd_addr | output | 19 | Captured write address |
| cmd_data | output | 8 | Captured write data |

## Verification
The strobe decoder is driven through all eight strobe combinations, including chip enable high with the other two strobes low and the undefined all-low case. This separates true standby from output-disable and shows the bus is never driven outside read. Writes are run once with write enable as the timing strobe and once with chip enable. In each, address and data change between the two edges, so a design that latches on the wrong edge or wrong strobe returns the wrong pair. Back-pressure runs hold `cmd_ready` low across a second write to show the hold and the replacement. Reads step through every {A6,A1,A0} pattern, every protected and unprotected block, and both normal sources with distinct bit patterns, so that a swapped code, a wrong block index or a misplaced status bit each changes the byte.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  typedef enum logic [1:0] {
    BM_STANDBY = 2'd0,
    BM_READ    = 2'd1,
    BM_WRITE   = 2'd2,
    BM_NODRIVE = 2'd3
  } bus_mode_e;

  localparam logic [7:0] MFR_ID = 8'h20;
  localparam logic [7:0] DEV_ID = 8'hE3;

  // status byte bit positions
  localparam int POS_POLL   = 7;
  localparam int POS_TOGGLE = 6;
  localparam int POS_ERROR  = 5;
  localparam int POS_ETIMER = 3;

  // signature selector {A6,A1,A0}
  localparam logic [2:0] SIG_MFR  = 3'b000;
  localparam logic [2:0] SIG_DEV  = 3'b001;
  localparam logic [2:0] SIG_PROT = 3'b010;
endpackage

// File: rtl/pflash_strobe_sync.sv
module pflash_strobe_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_n,
  output logic [WIDTH-1:0] sync_n
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw_n[i]};
    end
    assign sync_n[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/pflash_write_capture.sv
module pflash_write_capture #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_s_n,
  input  logic          oe_s_n,
  input  logic          we_s_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] dq_in,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  // write window: both write strobes low with outputs disabled
  logic          wr_act, wr_act_q, wr_start, wr_end;
  logic [AW-1:0] addr_hold;

  assign wr_act   = !ce_s_n && !we_s_n && oe_s_n;
  assign wr_start = wr_act && !wr_act_q;   // later strobe fell
  assign wr_end   = !wr_act && wr_act_q;   // earlier strobe rose

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q  <= 1'b0;
      addr_hold <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      wr_act_q <= wr_act;
      if (wr_start) addr_hold <= addr_in;
      if (wr_end) begin
        cmd_valid <= 1'b1;
        cmd_addr  <= addr_hold;
        cmd_data  <= dq_in;
      end else if (cmd_ready) begin
        cmd_valid <= 1'b0;
      end
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !wr_end) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_data)));

  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> cmd_valid);

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_end && !cmd_valid) |=> !cmd_valid);
endmodule

// File: rtl/pflash_read_mux.sv
module pflash_read_mux #(
  parameter int DW     = 8,
  parameter int NBLK   = 8,
  parameter int BLK_BITS = $clog2(NBLK)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a9_hv,
  input  logic [2:0]          sig_sel,
  input  logic [BLK_BITS-1:0] blk_idx,
  input  logic [NBLK-1:0]     blk_prot,
  input  logic                stat_sel,
  input  logic                st_poll,
  input  logic                st_toggle,
  input  logic                st_error,
  input  logic                st_etimer,
  input  logic [DW-1:0]       arr_rdata,
  output logic [DW-1:0]       rdata
);
  import pflash_pkg::*;

  logic [DW-1:0] sig_byte, stat_byte, nxt;

  always_comb begin
    sig_byte = '0;
    case (sig_sel)
      SIG_MFR:  sig_byte = DW'(MFR_ID);
      SIG_DEV:  sig_byte = DW'(DEV_ID);
      SIG_PROT: sig_byte = DW'(blk_prot[blk_idx]);
      default:  sig_byte = '0;
    endcase
  end

  always_comb begin
    stat_byte             = '0;
    stat_byte[POS_POLL]   = st_poll;
    stat_byte[POS_TOGGLE] = st_toggle;
    stat_byte[POS_ERROR]  = st_error;
    stat_byte[POS_ETIMER] = st_etimer;
  end

  always_comb begin
    if (a9_hv)         nxt = sig_byte;
    else if (stat_sel) nxt = stat_byte;
    else               nxt = arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= nxt;
  end

  p_mfr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a9_hv && sig_sel == 3'b000) |=> rdata == DW'(8'h20));

  p_dev_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a9_hv && sig_sel == 3'b001) |=> rdata == DW'(8'hE3));

  p_other_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a9_hv && sig_sel[2]) |=> rdata == '0);

  p_statpad_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!a9_hv && stat_sel) |=> (rdata[4] == 1'b0 && rdata[2:0] == 3'b000));
endmodule

// File: rtl/pflash_front.sv
module pflash_front #(
  parameter int AW          = 19,
  parameter int DW          = 8,
  parameter int NBLK        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] dq_in,
  input  logic          a9_hv,
  input  logic [DW-1:0] arr_rdata,
  input  logic          stat_sel,
  input  logic          st_poll,
  input  logic          st_toggle,
  input  logic          st_error,
  input  logic          st_etimer,
  input  logic [NBLK-1:0] blk_prot,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [1:0]    bus_mode,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  import pflash_pkg::*;

  localparam int BLK_BITS = $clog2(NBLK);

  logic [2:0] strb_s;
  logic       ce_s, oe_s, we_s;
  bus_mode_e  mode_d, mode_q;

  pflash_strobe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_n ({ce_n, oe_n, we_n}),
    .sync_n(strb_s)
  );
  assign {ce_s, oe_s, we_s} = strb_s;

  always_comb begin
    if (ce_s)               mode_d = BM_STANDBY;
    else if (!oe_s && we_s) mode_d = BM_READ;
    else if (oe_s && !we_s) mode_d = BM_WRITE;
    else                    mode_d = BM_NODRIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= BM_STANDBY;
      dq_oe  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      dq_oe  <= (mode_d == BM_READ);
    end
  end
  assign bus_mode = mode_q;

  pflash_write_capture #(.AW(AW), .DW(DW)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_s_n   (ce_s),
    .oe_s_n   (oe_s),
    .we_s_n   (we_s),
    .addr_in  (addr_in),
    .dq_in    (dq_in),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data)
  );

  pflash_read_mux #(.DW(DW), .NBLK(NBLK)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .a9_hv    (a9_hv),
    .sig_sel  ({addr_in[6], addr_in[1], addr_in[0]}),
    .blk_idx  (addr_in[AW-1 -: BLK_BITS]),
    .blk_prot (blk_prot),
    .stat_sel (stat_sel),
    .st_poll  (st_poll),
    .st_toggle(st_toggle),
    .st_error (st_error),
    .st_etimer(st_etimer),
    .arr_rdata(arr_rdata),
    .rdata    (dq_out)
  );

  p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_s |=> bus_mode == 2'd0);

  p_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_s || oe_s || !we_s) |=> !dq_oe);

  p_oe_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> bus_mode == 2'd1);
endmodule

// File: tb/pflash_front_tb.sv
module pflash_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [18:0] addr_in = '0;
  logic [7:0]  dq_in = '0;
  logic        a9_hv = 1'b0;
  logic [7:0]  arr_rdata = '0;
  logic        stat_sel = 1'b0;
  logic        st_poll = 1'b0, st_toggle = 1'b0, st_error = 1'b0, st_etimer = 1'b0;
  logic [7:0]  blk_prot = '0;
  logic        cmd_ready = 1'b1;
  logic [7:0]  dq_out;
  logic        dq_oe;
  logic [1:0]  bus_mode;
  logic        cmd_valid;
  logic [18:0] cmd_addr;
  logic [7:0]  cmd_data;

  int n_tests = 0, n_fail = 0;
  int hs_cnt = 0;
  logic [18:0] hs_addr;
  logic [7:0]  hs_data;
  bit done = 0;

  always #10 clk = ~clk;

  pflash_front u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr_in(addr_in), .dq_in(dq_in), .a9_hv(a9_hv), .arr_rdata(arr_rdata),
    .stat_sel(stat_sel), .st_poll(st_poll), .st_toggle(st_toggle),
    .st_error(st_error), .st_etimer(st_etimer), .blk_prot(blk_prot),
    .dq_out(dq_out), .dq_oe(dq_oe), .bus_mode(bus_mode),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  always @(posedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      hs_cnt  <= hs_cnt + 1;
      hs_addr <= cmd_addr;
      hs_data <= cmd_data;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic strobes(logic e, logic g, logic w);
    @(negedge clk);
    ce_n = e; oe_n = g; we_n = w;
    settle();
  endtask

  task automatic t_reset();
    // R11: state during and just after reset
    repeat (3) @(negedge clk);
    check("R11 dq_oe", dq_oe, 0);
    check("R11 cmd_valid", cmd_valid, 0);
    check("R11 cmd_addr", cmd_addr, 0);
    check("R11 cmd_data", cmd_data, 0);
    rst_n = 1'b1;
    settle();
    check("R11 bus_mode", bus_mode, 0);
    check("R11 dq_oe after", dq_oe, 0);
  endtask

  task automatic t_modes();
    // R1 / R2: all eight strobe combinations
    for (int i = 0; i < 8; i++) begin
      logic e, g, w;
      logic [1:0] exp_m;
      {e, g, w} = i[2:0];
      if (e) exp_m = 2'd0;
      else if (!g && w) exp_m = 2'd1;
      else if (g && !w) exp_m = 2'd2;
      else exp_m = 2'd3;
      strobes(e, g, w);
      check("R1 bus_mode", bus_mode, exp_m);
      check("R2 dq_oe", dq_oe, exp_m == 2'd1);
    end
    strobes(1, 1, 1);
    // R1: latency within 3 cycles
    @(negedge clk);
    ce_n = 0; oe_n = 0;
    repeat (3) @(negedge clk);
    check("R1 latency", bus_mode, 1);
    strobes(1, 1, 1);
  endtask

  task automatic t_wr_we();
    int base = hs_cnt;
    strobes(0, 1, 1);
    addr_in = 19'h12345; dq_in = 8'h11;
    settle();
    strobes(0, 1, 0);              // WE falls: address taken
    addr_in = 19'h7F00F; dq_in = 8'hA5;
    settle();
    strobes(0, 1, 1);              // WE rises: data taken
    dq_in = 8'h3C; addr_in = 19'h00001;
    settle();
    check("R3 count", hs_cnt - base, 1);
    check("R3 addr", hs_addr, 19'h12345);
    check("R3 data", hs_data, 8'hA5);
    check("R5 single pulse", cmd_valid, 0);
    strobes(1, 1, 1);
  endtask

  task automatic t_wr_ce();
    int base = hs_cnt;
    strobes(1, 1, 0);
    addr_in = 19'h2468A; dq_in = 8'h00;
    settle();
    strobes(0, 1, 0);              // CE falls: address taken
    addr_in = 19'h55555; dq_in = 8'h96;
    settle();
    strobes(1, 1, 0);              // CE rises: data taken
    dq_in = 8'hFF; addr_in = 19'h0;
    settle();
    check("R4 count", hs_cnt - base, 1);
    check("R4 addr", hs_addr, 19'h2468A);
    check("R4 data", hs_data, 8'h96);
    strobes(1, 1, 1);
  endtask

  task automatic one_write(logic [18:0] a, logic [7:0] d);
    addr_in = a;
    strobes(0, 1, 0);
    dq_in = d;
    settle();
    strobes(1, 1, 1);
  endtask

  task automatic t_backpressure();
    int base = hs_cnt;
    @(negedge clk) cmd_ready = 1'b0;
    one_write(19'h00AAA, 8'h5A);
    check("R5 valid held", cmd_valid, 1);
    repeat (10) @(negedge clk);
    check("R5 still held", cmd_valid, 1);
    check("R5 held addr", cmd_addr, 19'h00AAA);
    check("R5 held data", cmd_data, 8'h5A);
    check("R5 no handshake", hs_cnt - base, 0);
    one_write(19'h40001, 8'hC3);   // replaces pending write
    check("R5 replaced addr", cmd_addr, 19'h40001);
    @(negedge clk) cmd_ready = 1'b1;
    settle();
    check("R5 one handshake", hs_cnt - base, 1);
    check("R5 handshake data", hs_data, 8'hC3);
    check("R5 valid cleared", cmd_valid, 0);
  endtask

  task automatic rd(logic [18:0] a, logic [7:0] exp, string req);
    @(negedge clk) addr_in = a;
    repeat (2) @(negedge clk);
    check(req, dq_out, exp);
  endtask

  task automatic t_signature();
    strobes(0, 0, 1);
    check("R2 read drives", dq_oe, 1);
    a9_hv = 1'b1;
    blk_prot = 8'b1010_0110;
    arr_rdata = 8'h77;
    rd(19'h0_0000, 8'h20, "R6 manufacturer");
    rd(19'h3_FF00, 8'h20, "R6 upper bits ignored");
    rd(19'h0_0001, 8'hE3, "R7 device");
    for (int b = 0; b < 8; b++) begin
      logic [18:0] a = {b[2:0], 16'h0002};
      rd(a, {7'b0, blk_prot[b]}, "R8 block status");
    end
    rd(19'h0_0003, 8'h00, "R9 A1A0 both high");
    rd(19'h0_0040, 8'h00, "R9 A6 high");
    rd(19'h0_0041, 8'h00, "R9 A6 A0 high");
    rd(19'h0_0043, 8'h00, "R9 all high");
    a9_hv = 1'b0;
    strobes(1, 1, 1);
  endtask

  task automatic t_normal();
    strobes(0, 0, 1);
    arr_rdata = 8'h5C;
    stat_sel = 1'b0;
    rd(19'h0_0000, 8'h5C, "R10 array data");
    arr_rdata = 8'hA3;
    rd(19'h0_0001, 8'hA3, "R10 array data 2");
    stat_sel = 1'b1;
    st_poll = 1; st_toggle = 0; st_error = 1; st_etimer = 0;
    rd(19'h0_0000, 8'hA0, "R10 status poll+error");
    st_poll = 0; st_toggle = 1; st_error = 0; st_etimer = 1;
    rd(19'h0_0000, 8'h48, "R10 status toggle+timer");
    stat_sel = 1'b0;
    strobes(0, 1, 1);
    check("R2 output disable", dq_oe, 0);
    strobes(1, 1, 1);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_wr_we();
    t_wr_ce();
    t_backpressure();
    t_signature();
    t_normal();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule